// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address of a load or store and the new value of its base register. An offset is built first. It is either a 12-bit immediate, zero-extended, or a register operand shifted left by a 5-bit amount. The offset is then added to or subtracted from the base. A mode decoder reads the indexing bit and the writeback bit. From them it chooses whether the access uses the adjusted value or the untouched base, and whether the base register is to be rewritten.

The decoder has three named modes. PRE_HOLD is pre-indexed with no writeback: the address is base±offset and the base is kept. PRE_WRITE is pre-indexed with writeback: the address is base±offset and the base becomes that same value. POST_WRITE is post-indexed: the address is the untouched base, and the base always becomes base±offset, whatever the writeback bit holds. The arithmetic path is purely combinational. The parameter `REG_OUT` selects a single output register stage; it defaults to on, which gives one cycle of latency. The decoder holds no state between requests. Each request is decoded from its own control bits, so no transition depends on an earlier request.

Top module: `agu_ls_top`

## Requirements
- R1: With `ctl_regoff`=0 the offset is `imm_off` zero-extended to 32 bits. The upper 20 bits of the offset are always 0.
- R2: With `ctl_regoff`=1 the offset is `rm_val` shifted left logically by `shamt` (0..31). Bits shifted out are lost. A shift of 0 passes `rm_val` unchanged.
- R3: `ctl_up`=1 adds the offset to `base_val` and `ctl_up`=0 subtracts it. The result wraps modulo 2^32, and no overflow is reported.
- R4: With `ctl_pre`=1 (pre-indexed), `mem_addr` equals base±offset.
- R5: In pre-indexed mode `wb_en` equals `ctl_wb`. `wb_val` always carries base±offset.
- R6: With `ctl_pre`=0 (post-indexed), `mem_addr` equals the unmodified `base_val`. `wb_en` is 1 regardless of `ctl_wb`, and `wb_val` is base±offset.
- R7: `is_load` reproduces `ctl_load` of the same request (1 = load, 0 = store).
- R8: With `REG_OUT`=1, the results of a request sampled with `in_vld`=1 appear at the next rising edge, with `out_vld`=1. While `rst_n` is low, all outputs are 0.
- R9: `wb_en` is 0 whenever `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset |
| rm_val | input | 32 | Offset register value |
| shamt | input | 5 | Left shift amount for `rm_val` |
| ctl_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| ctl_up | input | 1 | 1 = add offset, 0 = subtract |
| ctl_wb | input | 1 | Writeback request (pre-indexed only) |
| ctl_load | input | 1 | 1 = load, 0 = store |
| ctl_regoff | input | 1 | 1 = shifted register offset, 0 = immediate |
| out_vld | output | 1 | Results valid |
| mem_addr | output | 32 | Effective access address |
| wb_val | output | 32 | New base register value |
| wb_en | output | 1 | Base register writeback enable |
| is_load | output | 1 | Load/store indication |

## Verification
Some properties are checked on every cycle:
- the one-cycle valid latency;
- the post-indexed rules, which are an untouched base as the address and a forced writeback;
- pre-indexed address equal to the writeback value, with writeback withheld when it is not requested;
- load flag passthrough;
- gating of `wb_en` by `out_vld`;
- the zero-shift register offset.

Other behaviour is shown only by the bench scenarios:
- the exact value of each sum or difference;
- zero-extension of the largest immediate;
- wraparound past zero and past 2^32;
- the full 31-bit shift;
- the reset values.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        AGU_PRE_HOLD   = 2'd0,
        AGU_PRE_WRITE  = 2'd1,
        AGU_POST_WRITE = 2'd2
    } agu_mode_e;
endpackage

// File: rtl/agu_offset_gen.sv
module agu_offset_gen #(
    parameter int DW    = 32,
    parameter int IMM_W = 12,
    parameter int SH_W  = 5
) (
    input  logic [IMM_W-1:0] imm_off,
    input  logic [DW-1:0]    rm_val,
    input  logic [SH_W-1:0]  shamt,
    input  logic             use_reg,
    output logic [DW-1:0]    offset
);
    localparam int PAD_W = DW - IMM_W;

    logic [DW-1:0] imm_ext;
    logic [DW-1:0] reg_shifted;

    assign imm_ext     = {{PAD_W{1'b0}}, imm_off};
    assign reg_shifted = rm_val << shamt;

    always_comb begin
        if (use_reg) offset = reg_shifted;
        else         offset = imm_ext;
    end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] offset,
    input  logic          add_n_sub,
    output logic [DW-1:0] result
);
    always_comb begin
        if (add_n_sub) result = base_val + offset;
        else           result = base_val - offset;
    end
endmodule

// File: rtl/agu_mode_dec.sv
module agu_mode_dec
    import agu_pkg::*;
(
    input  logic      pre_idx,
    input  logic      wb_req,
    output agu_mode_e mode,
    output logic      addr_from_upd,
    output logic      wb_enable
);
    always_comb begin
        if (!pre_idx)    mode = AGU_POST_WRITE;
        else if (wb_req) mode = AGU_PRE_WRITE;
        else             mode = AGU_PRE_HOLD;
    end

    always_comb begin
        unique case (mode)
            AGU_PRE_HOLD: begin
                addr_from_upd = 1'b1;
                wb_enable     = 1'b0;
            end
            AGU_PRE_WRITE: begin
                addr_from_upd = 1'b1;
                wb_enable     = 1'b1;
            end
            AGU_POST_WRITE: begin
                addr_from_upd = 1'b0;
                wb_enable     = 1'b1;
            end
            default: begin
                addr_from_upd = 1'b0;
                wb_enable     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/agu_ls_top.sv
module agu_ls_top
    import agu_pkg::*;
#(
    parameter int DW      = 32,
    parameter int IMM_W   = 12,
    parameter int SH_W    = 5,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [DW-1:0]    base_val,
    input  logic [IMM_W-1:0] imm_off,
    input  logic [DW-1:0]    rm_val,
    input  logic [SH_W-1:0]  shamt,
    input  logic             ctl_pre,
    input  logic             ctl_up,
    input  logic             ctl_wb,
    input  logic             ctl_load,
    input  logic             ctl_regoff,
    output logic             out_vld,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    wb_val,
    output logic             wb_en,
    output logic             is_load
);
    logic [DW-1:0] offset;
    logic [DW-1:0] upd_val;
    agu_mode_e     mode;
    logic          addr_from_upd;
    logic          wb_enable;

    logic [DW-1:0] nxt_addr;
    logic [DW-1:0] nxt_wbv;
    logic          nxt_wben;
    logic          nxt_load;

    agu_offset_gen #(.DW(DW), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
        .imm_off (imm_off),
        .rm_val  (rm_val),
        .shamt   (shamt),
        .use_reg (ctl_regoff),
        .offset  (offset)
    );

    agu_addsub #(.DW(DW)) u_addsub (
        .base_val  (base_val),
        .offset    (offset),
        .add_n_sub (ctl_up),
        .result    (upd_val)
    );

    agu_mode_dec u_dec (
        .pre_idx       (ctl_pre),
        .wb_req        (ctl_wb),
        .mode          (mode),
        .addr_from_upd (addr_from_upd),
        .wb_enable     (wb_enable)
    );

    always_comb begin
        nxt_addr = addr_from_upd ? upd_val : base_val;
        nxt_wbv  = upd_val;
        nxt_wben = wb_enable & in_vld;
        nxt_load = ctl_load;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_vld  <= 1'b0;
                    mem_addr <= '0;
                    wb_val   <= '0;
                    wb_en    <= 1'b0;
                    is_load  <= 1'b0;
                end else begin
                    out_vld  <= in_vld;
                    mem_addr <= nxt_addr;
                    wb_val   <= nxt_wbv;
                    wb_en    <= nxt_wben;
                    is_load  <= nxt_load;
                end
            end
        end else begin : g_comb
            always_comb begin
                out_vld  = in_vld;
                mem_addr = nxt_addr;
                wb_val   = nxt_wbv;
                wb_en    = nxt_wben;
                is_load  = nxt_load;
            end
        end
    endgenerate
endmodule

// File: rtl/agu_ls_chk.sv
module agu_ls_chk #(
    parameter int DW      = 32,
    parameter int SH_W    = 5,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [DW-1:0]   base_val,
    input logic [DW-1:0]   rm_val,
    input logic [SH_W-1:0] shamt,
    input logic            ctl_pre,
    input logic            ctl_up,
    input logic            ctl_wb,
    input logic            ctl_load,
    input logic            ctl_regoff,
    input logic            out_vld,
    input logic [DW-1:0]   mem_addr,
    input logic [DW-1:0]   wb_val,
    input logic            wb_en,
    input logic            is_load
);
    generate
        if (REG_OUT) begin : g_seq
            AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld == $past(in_vld)); // R8
            AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && !ctl_pre) |=> (mem_addr == $past(base_val))); // R6
            AST_POST_WB: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && !ctl_pre) |=> wb_en); // R6
            AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && ctl_pre) |=> (mem_addr == wb_val)); // R4
            AST_PRE_WB: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && ctl_pre) |=> (wb_en == $past(ctl_wb))); // R5
            AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                in_vld |=> (is_load == $past(ctl_load))); // R7
            AST_WB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
                wb_en |-> out_vld); // R9
            AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && ctl_regoff && ctl_up && shamt == '0) |=>
                (wb_val == $past(base_val + rm_val))); // R2
        end else begin : g_imm
            always_comb begin
                AST_WB_GATED_C: assert (!wb_en || out_vld); // R9
            end
        end
    endgenerate
endmodule

bind agu_ls_top agu_ls_chk #(.DW(DW), .SH_W(SH_W), .REG_OUT(REG_OUT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .base_val   (base_val),
    .rm_val     (rm_val),
    .shamt      (shamt),
    .ctl_pre    (ctl_pre),
    .ctl_up     (ctl_up),
    .ctl_wb     (ctl_wb),
    .ctl_load   (ctl_load),
    .ctl_regoff (ctl_regoff),
    .out_vld    (out_vld),
    .mem_addr   (mem_addr),
    .wb_val     (wb_val),
    .wb_en      (wb_en),
    .is_load    (is_load)
);

// File: tb/agu_ls_top_tb_top.sv
`timescale 1ns/1ps
module agu_ls_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] base_val = '0;
    logic [11:0] imm_off = '0;
    logic [31:0] rm_val = '0;
    logic [4:0]  shamt = '0;
    logic        ctl_pre = 1'b0, ctl_up = 1'b0, ctl_wb = 1'b0;
    logic        ctl_load = 1'b0, ctl_regoff = 1'b0;
    logic        out_vld, wb_en, is_load;
    logic [31:0] mem_addr, wb_val;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] wbv;
        logic        wben;
        logic        ld;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    agu_ls_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .base_val(base_val),
        .imm_off(imm_off), .rm_val(rm_val), .shamt(shamt), .ctl_pre(ctl_pre),
        .ctl_up(ctl_up), .ctl_wb(ctl_wb), .ctl_load(ctl_load),
        .ctl_regoff(ctl_regoff), .out_vld(out_vld), .mem_addr(mem_addr),
        .wb_val(wb_val), .wb_en(wb_en), .is_load(is_load)
    );

    task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] b, logic [11:0] im, logic [31:0] rm,
                         logic [4:0] sh, logic p, logic u, logic w, logic l,
                         logic ro, string tag);
        exp_t e;
        logic [31:0] off;
        logic [31:0] upd;
        @(negedge clk);
        base_val = b; imm_off = im; rm_val = rm; shamt = sh;
        ctl_pre = p; ctl_up = u; ctl_wb = w; ctl_load = l; ctl_regoff = ro;
        in_vld = 1'b1;
        off    = ro ? (rm << sh) : {20'b0, im};
        upd    = u ? b + off : b - off;
        e.addr = p ? upd : b;
        e.wbv  = upd;
        e.wben = !p || w;
        e.ld   = l;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            ctl_wb = 1'b1;
            ctl_pre = 1'b0;
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_vld) begin
                if (sb_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R8 unexpected out_vld actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check32(e.tag, "mem_addr", mem_addr, e.addr);
                    check32(e.tag, "wb_val", wb_val, e.wbv);
                    check32(e.tag, "wb_en", {31'b0, wb_en}, {31'b0, e.wben});
                    check32({e.tag, " R7"}, "is_load", {31'b0, is_load}, {31'b0, e.ld});
                end
            end else begin
                check32("R9", "wb_en idle", {31'b0, wb_en}, 32'd0);
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check32("R8", "reset out_vld", {31'b0, out_vld}, 32'd0);
        check32("R8", "reset mem_addr", mem_addr, 32'd0);
        check32("R8", "reset wb_val", wb_val, 32'd0);
        check32("R8", "reset wb_en", {31'b0, wb_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(32'h0000_1000, 12'h019, 32'h0, 5'd0, 1, 1, 0, 1, 0, "R1 R4 R5 pre-hold imm");
        drive(32'h0000_2000, 12'h0, 32'h3, 5'd2, 1, 1, 1, 1, 1, "R2 R5 pre-write reg<<2");
        drive(32'h0000_0100, 12'h004, 32'h0, 5'd0, 0, 0, 0, 1, 0, "R3 R6 post down wb=0");
        drive(32'h0000_0100, 12'h004, 32'h0, 5'd0, 0, 1, 1, 0, 0, "R6 R7 post up store");
        drive(32'h0000_0040, 12'h0, 32'h1234_5678, 5'd0, 1, 1, 0, 1, 1, "R2 shift zero");
        drive(32'h0000_0000, 12'hFFF, 32'h0, 5'd0, 1, 0, 1, 1, 0, "R1 R3 max imm below zero");
        drive(32'hFFFF_FFF0, 12'h020, 32'h0, 5'd0, 1, 1, 1, 0, 0, "R3 wrap up");
        drive(32'h0000_0010, 12'h0, 32'h0000_0003, 5'd31, 1, 1, 0, 0, 1, "R2 shift 31");
        drive(32'h8000_0000, 12'h800, 32'hFFFF_FFFF, 5'd4, 1, 0, 0, 0, 0, "R1 imm ignores rm");
        idle(3);
        drive(32'h0000_5000, 12'h0, 32'h10, 5'd3, 0, 0, 1, 0, 1, "R6 post reg down");
        idle(1);
        for (int i = 0; i < 40; i++) begin
            drive($urandom, 12'($urandom), $urandom, 5'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), "R4 R6 random");
        end
        idle(4);
        check32("R8", "scoreboard drained", sb_q.size(), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule